// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count for a SCSI controller's DMA engine. Software programs the count as three separate bytes. Those bytes sit in a staging copy until a command arrives with its DMA flag set. That command moves the staged value into the loaded count, which is the value software reads back. A command without the flag drops the engine out of DMA mode and leaves the loaded count unchanged.

When a transfer is started in DMA mode, the block sets its remaining count. The remaining count is the smaller of two values:
- The loaded count. A loaded count of zero stands for 65536 bytes.
- A limit. This is the size of the internal command buffer while a command is being gathered, and otherwise the amount of data the target still has to move.

The remaining count then falls by the bytes accepted in each beat. A transfer-count-zero flag rises on the edge where the count runs out.

Reading the top count byte returns a fixed identification value until software writes that byte for the first time after a hardware or soft reset.

Top module: `dma_count_ctr`

## Requirements
- R1: After hardware reset `remaining` is 0, `tcZero` is 0, `dmaMode` is 0, read selects 0 and 1 return 0, and read select 2 returns `CHIP_ID`.
- R2: A write with `wrSel` 0 (low), 1 (middle) or 2 (high) updates only the staging byte. `rdData` with `rdSel` 0/1/2 returns the loaded count byte, so it does not change until a DMA command. `wrSel` 3 has no effect.
- R3: `cmdValid` with `cmdDma`=1 copies all staging bytes into the loaded count and sets `dmaMode`. With `cmdDma`=0 it clears `dmaMode` and keeps the loaded count. If a write and a command fall in the same cycle, the command copies the staging value from before the write.
- R4: `rdSel` 2 returns `CHIP_ID` until a write with `wrSel` 2 has occurred since the last reset. After that it returns loaded bits 23:16. `rdSel` 3 returns 0.
- R5: `xferStart` while `dmaMode` is 1 loads `remaining` on the next edge with min(P, L). P is the loaded count, or 65536 when the loaded count is zero. L is `CMD_LIMIT` when `cmdCollect` is 1, and `remainLen` otherwise.
- R6: `xferStart` while `dmaMode` is 0 has no effect on `remaining` or `tcZero`.
- R7: `beatValid` while `remaining` is nonzero lowers `remaining` by min(`beatBytes`, `remaining`). A beat while `remaining` is 0 is ignored. A start in the same cycle takes priority over a beat.
- R8: `tcZero` becomes 1 on the same edge at which a beat brings `remaining` to 0. It then holds until it is cleared.
- R9: A write with `wrSel` 0, 1 or 2 clears `tcZero` on the next edge. This write wins over a beat that reaches zero in the same cycle.
- R10: An accepted transfer start clears `tcZero`.
- R11: `softReset` returns every register to its R1 state on the next edge, including the staging bytes and the high-byte written flag. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| softReset | input | 1 | Synchronous soft reset |
| wrEn | input | 1 | Count byte write strobe |
| wrSel | input | 2 | Byte select for writes |
| wrData | input | 8 | Write data |
| cmdValid | input | 1 | Command issued this cycle |
| cmdDma | input | 1 | DMA flag of the command |
| xferStart | input | 1 | Start a transfer |
| cmdCollect | input | 1 | Transfer gathers a command (use buffer limit) |
| remainLen | input | 25 | Bytes the target still has to transfer |
| beatValid | input | 1 | Bytes accepted this cycle |
| beatBytes | input | 3 | Number of bytes in the beat |
| rdSel | input | 2 | Byte select for readback |
| rdData | output | 8 | Readback byte |
| dmaMode | output | 1 | DMA mode latched from the last command |
| remaining | output | 25 | Remaining transfer count |
| tcZero | output | 1 | Transfer count reached zero |

## Verification
The assertions treat every input as a synchronous level that is sampled once per edge. They also assume `softReset` overrides every other input in the same cycle. Nothing in them depends on the inputs being mutually exclusive.

The bench therefore drives every input on the falling edge, so each input is stable across the edge that samples it. Its random phase mixes in collisions freely: a write and a zero-reaching beat in the same cycle, a start and a beat together, and a command and a write together. `remainLen` is kept small so that transfers finish within the run, while the all-zero count still yields 65536 under command collection and in the directed steps.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  localparam int NUM_BYTES = 3;

  typedef struct packed {
    logic [NUM_BYTES-1:0] loadByte;
    logic                 reload;
    logic                 start;
    logic                 useCmdLimit;
    logic                 beat;
    logic                 clearTc;
    logic                 softClr;
  } ctlStrobes_t;
endpackage

// File: rtl/dma_cnt_ctrl.sv
module dma_cnt_ctrl
  import dma_cnt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        softReset,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic        cmdValid,
  input  logic        cmdDma,
  input  logic        xferStart,
  input  logic        cmdCollect,
  input  logic        beatValid,
  output ctlStrobes_t strobes,
  output logic        dmaMode,
  output logic        hiWritten
);
  localparam logic [1:0] HI_SEL = 2'(NUM_BYTES - 1);

  always_comb begin
    strobes = '0;
    strobes.softClr = softReset;
    if (!softReset) begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        strobes.loadByte[i] = wrEn && (wrSel == 2'(i));
      end
      strobes.reload      = cmdValid && cmdDma;
      strobes.start       = xferStart && dmaMode;
      strobes.useCmdLimit = cmdCollect;
      strobes.beat        = beatValid;
    end
    strobes.clearTc = |strobes.loadByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmaMode   <= 1'b0;
      hiWritten <= 1'b0;
    end else if (softReset) begin
      dmaMode   <= 1'b0;
      hiWritten <= 1'b0;
    end else begin
      if (cmdValid) dmaMode <= cmdDma;
      if (wrEn && wrSel == HI_SEL) hiWritten <= 1'b1;
    end
  end

  AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hiWritten && !softReset |=> hiWritten); // R4
  AST_MODE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !softReset |=> dmaMode == $past(cmdDma)); // R3
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> !dmaMode && !hiWritten); // R11
endmodule

// File: rtl/dma_cnt_datapath.sv
module dma_cnt_datapath
  import dma_cnt_pkg::*;
#(
  parameter int          REM_W     = 25,
  parameter int          BEAT_W    = 3,
  parameter int          CMD_LIMIT = 16,
  parameter int          ZERO_LEN  = 65536,
  parameter logic [7:0]  CHIP_ID   = 8'hA2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [7:0]        wrData,
  input  logic [REM_W-1:0]  remainLen,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic [1:0]        rdSel,
  input  logic              hiWritten,
  output logic [REM_W-1:0]  remaining,
  output logic              tcZero,
  output logic [7:0]        rdData
);
  localparam int CNT_W = NUM_BYTES * 8;

  logic [NUM_BYTES-1:0][7:0] stageQ;
  logic [NUM_BYTES-1:0][7:0] loadedQ;
  logic [REM_W-1:0] progLen, limitLen, effLen, beatExt, accepted;
  logic hitZero;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stageQ[b]  <= '0;
        loadedQ[b] <= '0;
      end else if (strobes.softClr) begin
        stageQ[b]  <= '0;
        loadedQ[b] <= '0;
      end else begin
        if (strobes.reload) loadedQ[b] <= stageQ[b];
        if (strobes.loadByte[b]) stageQ[b] <= wrData;
      end
    end
  end

  always_comb begin
    progLen  = (loadedQ == '0) ? REM_W'(ZERO_LEN) : REM_W'(CNT_W'(loadedQ));
    limitLen = strobes.useCmdLimit ? REM_W'(CMD_LIMIT) : remainLen;
    effLen   = (progLen < limitLen) ? progLen : limitLen;
    beatExt  = REM_W'(beatBytes);
    accepted = (beatExt < remaining) ? beatExt : remaining;
    hitZero  = strobes.beat && !strobes.start && (remaining != '0)
               && (accepted == remaining);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      tcZero    <= 1'b0;
    end else if (strobes.softClr) begin
      remaining <= '0;
      tcZero    <= 1'b0;
    end else begin
      if (strobes.start) remaining <= effLen;
      else if (strobes.beat) remaining <= remaining - accepted;
      if (strobes.clearTc || strobes.start) tcZero <= 1'b0;
      else if (hitZero) tcZero <= 1'b1;
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (rdSel == 2'(i)) begin
        rdData = (i == NUM_BYTES - 1 && !hiWritten) ? CHIP_ID : loadedQ[i];
      end
    end
  end

  AST_TC_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    hitZero && !strobes.clearTc && !strobes.softClr |=> tcZero && remaining == '0); // R8
  AST_WRITE_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearTc |=> !tcZero); // R9
  AST_START_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.start |=> !tcZero); // R10
  AST_START_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.start && !strobes.softClr |=> remaining <= $past(progLen)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.beat && !strobes.start && !strobes.softClr |=> remaining <= $past(remaining)); // R7
endmodule

// File: rtl/dma_count_ctr.sv
module dma_count_ctr
  import dma_cnt_pkg::*;
#(
  parameter int         REM_W     = 25,
  parameter int         BEAT_W    = 3,
  parameter int         CMD_LIMIT = 16,
  parameter int         ZERO_LEN  = 65536,
  parameter logic [7:0] CHIP_ID   = 8'hA2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softReset,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [7:0]        wrData,
  input  logic              cmdValid,
  input  logic              cmdDma,
  input  logic              xferStart,
  input  logic              cmdCollect,
  input  logic [REM_W-1:0]  remainLen,
  input  logic              beatValid,
  input  logic [BEAT_W-1:0] beatBytes,
  input  logic [1:0]        rdSel,
  output logic [7:0]        rdData,
  output logic              dmaMode,
  output logic [REM_W-1:0]  remaining,
  output logic              tcZero
);
  ctlStrobes_t strobes;
  logic hiWritten;

  dma_cnt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .wrEn(wrEn), .wrSel(wrSel),
    .cmdValid(cmdValid), .cmdDma(cmdDma), .xferStart(xferStart),
    .cmdCollect(cmdCollect), .beatValid(beatValid), .strobes(strobes),
    .dmaMode(dmaMode), .hiWritten(hiWritten)
  );

  dma_cnt_datapath #(
    .REM_W(REM_W), .BEAT_W(BEAT_W), .CMD_LIMIT(CMD_LIMIT),
    .ZERO_LEN(ZERO_LEN), .CHIP_ID(CHIP_ID)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .remainLen(remainLen), .beatBytes(beatBytes), .rdSel(rdSel),
    .hiWritten(hiWritten), .remaining(remaining), .tcZero(tcZero), .rdData(rdData)
  );
endmodule

// File: tb/dma_count_ctr_test.sv
module dma_count_ctr_test;
  localparam int CHIP = 8'hA2;
  localparam int CMDLIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic softReset = 0, wrEn = 0, cmdValid = 0, cmdDma = 0, xferStart = 0, cmdCollect = 0, beatValid = 0;
  logic [1:0] wrSel = 0, rdSel = 0;
  logic [7:0] wrData = 0;
  logic [24:0] remainLen = 0;
  logic [2:0] beatBytes = 0;
  logic [7:0] rdData;
  logic dmaMode, tcZero;
  logic [24:0] remaining;

  int nChecks = 0, nBad = 0;
  string curReq = "R1";

  int mStage[3], mLoaded, mHiW, mMode, mRem, mTc;

  always #10 clk = ~clk;

  dma_count_ctr uut (.*);

  task automatic modelReset();
    for (int i = 0; i < 3; i++) mStage[i] = 0;
    mLoaded = 0; mHiW = 0; mMode = 0; mRem = 0; mTc = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rst_n || softReset) modelReset();
    else begin
      int prog, lim, acc;
      if (xferStart && mMode) begin
        prog = (mLoaded == 0) ? 65536 : mLoaded;
        lim = cmdCollect ? CMDLIM : int'(remainLen);
        mRem = (prog < lim) ? prog : lim;
        mTc = 0;
      end else if (beatValid && mRem != 0) begin
        acc = (int'(beatBytes) < mRem) ? int'(beatBytes) : mRem;
        mRem -= acc;
        if (mRem == 0) mTc = 1;
      end
      if (cmdValid) begin
        mMode = cmdDma;
        if (cmdDma) mLoaded = mStage[0] + (mStage[1] << 8) + (mStage[2] << 16);
      end
      if (wrEn && wrSel != 2'd3) begin
        mStage[wrSel] = wrData;
        mTc = 0;
        if (wrSel == 2'd2) mHiW = 1;
      end
    end
  end

  function automatic int mRd(int sel);
    case (sel)
      0: return mLoaded & 8'hFF;
      1: return (mLoaded >> 8) & 8'hFF;
      2: return mHiW ? ((mLoaded >> 16) & 8'hFF) : CHIP;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(curReq, int'(remaining), mRem);
    chk(curReq, int'(tcZero), mTc);
    chk(curReq, int'(dmaMode), mMode);
    chk(curReq, int'(rdData), mRd(int'(rdSel)));
    softReset = 0; wrEn = 0; cmdValid = 0; xferStart = 0; beatValid = 0;
  endtask

  task automatic wr(int sel, int val);
    wrEn = 1; wrSel = 2'(sel); wrData = 8'(val); cyc();
  endtask

  task automatic cmd(int dma);
    cmdValid = 1; cmdDma = 1'(dma); cyc();
  endtask

  task automatic start(int rl, int coll);
    xferStart = 1; remainLen = 25'(rl); cmdCollect = 1'(coll); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rdSel = 2; cyc();
    chk("R1", int'(rdData), CHIP); chk("R1", int'(remaining), 0);
    chk("R1", int'(tcZero), 0); chk("R1", int'(dmaMode), 0);
    rdSel = 0; cyc(); chk("R1", int'(rdData), 0);

    curReq = "R2";
    wr(0, 8'h20); wr(1, 0); wr(3, 8'h55);
    chk("R2", int'(rdData), 0);
    curReq = "R3";
    cmd(1);
    chk("R3", int'(rdData), 8'h20); chk("R3", int'(dmaMode), 1);
    rdSel = 2; cyc(); chk("R4", int'(rdData), CHIP);

    curReq = "R7";
    start(256, 0); chk("R5", int'(remaining), 32);
    beatBytes = 7;
    for (int i = 0; i < 4; i++) begin beatValid = 1; cyc(); end
    chk("R7", int'(remaining), 4); chk("R8", int'(tcZero), 0);
    beatValid = 1; cyc();
    chk("R8", int'(remaining), 0); chk("R8", int'(tcZero), 1);
    beatValid = 1; cyc(); chk("R7", int'(remaining), 0); chk("R8", int'(tcZero), 1);

    curReq = "R9";
    wr(0, 0); chk("R9", int'(tcZero), 0);
    wr(1, 0); wr(2, 0);
    cmd(1); rdSel = 2; cyc(); chk("R4", int'(rdData), 0);

    curReq = "R5";
    start(65541, 0); chk("R5", int'(remaining), 65536);
    start(65541, 1); chk("R5", int'(remaining), CMDLIM);
    wr(0, 8'h30); cmd(1); start(8'h10, 0); chk("R5", int'(remaining), 16);

    curReq = "R6";
    cmd(0); chk("R6", int'(dmaMode), 0);
    start(3, 0); chk("R6", int'(remaining), 16);

    curReq = "R9";
    cmd(1); start(3, 0);
    beatValid = 1; beatBytes = 5; wrEn = 1; wrSel = 1; wrData = 0; cyc();
    chk("R9", int'(remaining), 0); chk("R9", int'(tcZero), 0);

    curReq = "R10";
    start(2, 0); beatValid = 1; cyc(); chk("R8", int'(tcZero), 1);
    start(9, 0); chk("R10", int'(tcZero), 0); chk("R10", int'(remaining), 9);

    curReq = "R11";
    softReset = 1; wrEn = 1; wrSel = 2; wrData = 8'h77; rdSel = 2; cyc();
    chk("R11", int'(rdData), CHIP); chk("R11", int'(remaining), 0); chk("R11", int'(dmaMode), 0);
    cmd(1); rdSel = 0; cyc(); chk("R11", int'(rdData), 0);

    curReq = "R7";
    for (int i = 0; i < 3000; i++) begin
      softReset  = ($urandom_range(0, 199) == 0);
      wrEn       = ($urandom_range(0, 7) == 0);
      wrSel      = 2'($urandom_range(0, 3));
      wrData     = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      cmdValid   = ($urandom_range(0, 9) == 0);
      cmdDma     = ($urandom_range(0, 3) != 0);
      xferStart  = ($urandom_range(0, 15) == 0);
      cmdCollect = ($urandom_range(0, 3) == 0);
      remainLen  = 25'($urandom_range(0, 300));
      beatValid  = ($urandom_range(0, 2) != 0);
      beatBytes  = 3'($urandom_range(0, 7));
      rdSel      = 2'($urandom_range(0, 3));
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule